// File: doc/BRIEF.md
# Fan-Out Sequencer and Bus Distributor

This block turns one pointer/count pair from an upstream lookup stage into a series of output events. It accepts the pair over a four-phase handshake. It then reads a second-level table once per entry, starting at `pointer + count - 1` and working down to `pointer`. Each table word carries a 16-bit event address and a 4-bit port-select mask. The address is placed on a shared output bus, and a four-phase request is raised on every output port whose mask bit is set. All of those ports run their handshakes in parallel.

The next table address is computed and held in the address counter while the current entry is being distributed. The next read is issued only after every selected port has finished its handshake and the output address has been held for a guard interval. The same guard interval applies before any request rises. An entry with an all-zero mask is read but produces no requests. When the entry at `pointer` has been distributed, the block acknowledges the lookup stage.

Top module: `fanout_sequencer`

## Requirements
- R1: While reset is asserted and immediately after it is released, `job_ack`, `tbl_rd` and every `out_req` bit are 0.
- R2: For a job with pointer P and count N (N > 0), the block issues exactly N table reads, one per entry, at addresses P+N-1, P+N-2, down to P, in that order.
- R3: In a table word, bits [15:0] are the event address and bits [19:16] are the port mask, where bit 16+i selects port i. Bits [23:20] have no effect on any output.
- R4: For each entry, `out_req[i]` is raised, with `out_addr` equal to the entry's event address, exactly when mask bit i is set. For example, mask 0101 raises ports 0 and 2 together, and no other port is raised.
- R5: Each port holds its request until its acknowledge rises. The next table read is issued only after every selected port has dropped its request and seen its acknowledge fall. Ports with a clear mask bit do not take part.
- R6: `out_addr` is stable for at least GUARD cycles (default 1) before any `out_req` bit rises, and for at least GUARD cycles after all handshakes have returned to idle.
- R7: An entry whose mask is 0000 raises no request, and the block continues with the next entry.
- R8: After the last entry, `job_ack` rises and stays high while `job_req` is high. It falls after `job_req` falls, and the block then accepts a new job.
- R9: A job with count 0 performs no table read and no output request, and is acknowledged directly.
- R10: A count of 8191 (the largest 13-bit value) is handled in full: 8191 reads in descending order.
- R11: The pointer and count are captured when the job is accepted. Later changes on `job_ptr` or `job_cnt` during the job have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_req | input | 1 | Job request from the lookup stage (four-phase) |
| job_ptr | input | 19 | First table address of the block of entries |
| job_cnt | input | 13 | Number of entries to read |
| job_ack | output | 1 | Job completion acknowledge (four-phase) |
| tbl_rd | output | 1 | Table read strobe; data is returned one cycle later |
| tbl_addr | output | 19 | Table read address |
| tbl_rdata | input | 24 | Table word, valid the cycle after `tbl_rd` |
| out_addr | output | 16 | Event address shared by all output ports |
| out_req | output | 4 | Per-port output request |
| out_ack | input | 4 | Per-port output acknowledge |

## Verification
Two functions can land in the same clock edge:
- two or more ports finishing their handshakes together;
- the last port to finish clearing the distributor while other ports are already idle.

The bench provokes the first case with equal acknowledge delays on all four ports and all-ones masks, and the second with unequal, staggered delays. It judges the result by the table read sequence and by a monitor. The monitor flags any read that is issued while a request or acknowledge is still high, and measures the address guard margin on both sides of every request.

// File: rtl/fos_pkg.sv
package fos_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_READ, S_WAIT, S_ENTRY, S_SETUP, S_REQ, S_HOLD, S_NEXT, S_DONE
  } fos_state_t;
endpackage

// File: rtl/fos_addr_gen.sv
module fos_addr_gen #(
  parameter int AW = 19,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ptr,
  input  logic [CW-1:0] cnt,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          left_zero
);
  function automatic logic [AW-1:0] top_addr(input logic [AW-1:0] p, input logic [CW-1:0] n);
    return p + AW'(n) - AW'(1);
  endfunction

  logic [CW-1:0] left_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      left_q <= '0;
      base_q <= '0;
    end else if (load) begin
      cur    <= top_addr(ptr, cnt);
      left_q <= cnt;
      base_q <= ptr;
    end else if (step) begin
      cur    <= cur - AW'(1);
      left_q <= left_q - CW'(1);
    end
  end

  assign left_zero = (left_q == '0);

  assert_not_below_ptr_R2: assert property (@(posedge clk) disable iff (rst)
    step |-> (cur >= base_q));
  assert_no_extra_read_R10: assert property (@(posedge clk) disable iff (rst)
    step |-> !left_zero);
endmodule

// File: rtl/fos_guard_timer.sv
module fos_guard_timer #(
  parameter int GUARD = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic expired
);
  localparam int GW = $clog2(GUARD + 2);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (arm)           cnt_q <= GW'(GUARD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - GW'(1);
  end

  assign expired = (cnt_q == '0) && !arm;
endmodule

// File: rtl/fos_port_hs.sv
module fos_port_hs (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic busy
);
  logic drain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      if (start) req <= 1'b1;
      else if (req && ack) begin
        req     <= 1'b0;
        drain_q <= 1'b1;
      end else if (drain_q && !ack) drain_q <= 1'b0;
    end
  end

  assign busy = req | drain_q;

  assert_req_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  assert_no_restart_busy_R5: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/fanout_sequencer.sv
module fanout_sequencer
  import fos_pkg::*;
#(
  parameter int AW    = 19,
  parameter int CW    = 13,
  parameter int EW    = 16,
  parameter int NPORT = 4,
  parameter int WW    = 24,
  parameter int GUARD = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             job_req,
  input  logic [AW-1:0]    job_ptr,
  input  logic [CW-1:0]    job_cnt,
  output logic             job_ack,
  output logic             tbl_rd,
  output logic [AW-1:0]    tbl_addr,
  input  logic [WW-1:0]    tbl_rdata,
  output logic [EW-1:0]    out_addr,
  output logic [NPORT-1:0] out_req,
  input  logic [NPORT-1:0] out_ack
);
  localparam int AGEW = $clog2(GUARD + 2);
  localparam logic [AGEW-1:0] AGE_MAX = AGEW'(GUARD + 1);

  function automatic logic [EW-1:0] word_addr(input logic [WW-1:0] w);
    return w[EW-1:0];
  endfunction
  function automatic logic [NPORT-1:0] word_mask(input logic [WW-1:0] w);
    return w[EW +: NPORT];
  endfunction

  fos_state_t state, state_nx;
  logic [NPORT-1:0] mask_q, busy, start_vec, req_prev;
  logic [EW-1:0]    addr_q;
  logic             accept, step, addr_load, left_zero, all_idle;
  logic             t_arm, t_expired;
  logic [AGEW-1:0]  age_addr, age_low;

  assign accept    = (state == S_IDLE) && job_req;
  assign step      = (state == S_READ);
  assign addr_load = (state == S_WAIT);
  assign all_idle  = (busy == '0);
  assign t_arm     = ((state == S_ENTRY) && (mask_q != '0)) ||
                     ((state == S_REQ) && all_idle);
  assign start_vec = ((state == S_SETUP) && t_expired) ? mask_q : '0;

  fos_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .ptr(job_ptr), .cnt(job_cnt),
    .step(step), .cur(tbl_addr), .left_zero(left_zero)
  );

  fos_guard_timer #(.GUARD(GUARD)) u_guard (
    .clk(clk), .rst(rst), .arm(t_arm), .expired(t_expired)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    fos_port_hs u_hs (
      .clk(clk), .rst(rst), .start(start_vec[i]), .ack(out_ack[i]),
      .req(out_req[i]), .busy(busy[i])
    );
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (job_req) state_nx = (job_cnt == '0) ? S_DONE : S_READ;
      S_READ:  state_nx = S_WAIT;
      S_WAIT:  state_nx = S_ENTRY;
      S_ENTRY: state_nx = (mask_q == '0) ? S_NEXT : S_SETUP;
      S_SETUP: if (t_expired) state_nx = S_REQ;
      S_REQ:   if (all_idle) state_nx = S_HOLD;
      S_HOLD:  if (t_expired) state_nx = S_NEXT;
      S_NEXT:  state_nx = left_zero ? S_DONE : S_READ;
      S_DONE:  if (!job_req) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      mask_q <= '0;
      addr_q <= '0;
    end else begin
      state <= state_nx;
      if (addr_load) begin
        mask_q <= word_mask(tbl_rdata);
        addr_q <= word_addr(tbl_rdata);
      end
    end
  end

  assign job_ack  = (state == S_DONE);
  assign tbl_rd   = step;
  assign out_addr = addr_q;

  // Observation state for the guard-margin assertions
  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      age_addr <= AGE_MAX;
      age_low  <= AGE_MAX;
    end else begin
      req_prev <= out_req;
      if (addr_load)              age_addr <= '0;
      else if (age_addr != AGE_MAX) age_addr <= age_addr + AGEW'(1);
      if (!all_idle)              age_low <= '0;
      else if (age_low != AGE_MAX) age_low <= age_low + AGEW'(1);
    end
  end

  assert_mask_only_R4: assert property (@(posedge clk) disable iff (rst)
    (out_req & ~mask_q) == '0);
  assert_read_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    tbl_rd |-> (busy == '0) && (out_req == '0));
  assert_guard_pre_R6: assert property (@(posedge clk) disable iff (rst)
    ((out_req & ~req_prev) != '0) |-> (age_addr >= AGEW'(GUARD)));
  assert_guard_post_R6: assert property (@(posedge clk) disable iff (rst)
    addr_load |-> (age_low >= AGEW'(GUARD)));
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (job_ack && job_req) |=> job_ack);
  assert_empty_job_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && (job_cnt == '0)) |=> (job_ack && !tbl_rd));
endmodule

// File: tb/tb_fanout_sequencer.sv
module tb_fanout_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        job_req = 1'b0;
  logic [18:0] job_ptr = '0;
  logic [12:0] job_cnt = '0;
  logic        job_ack, tbl_rd;
  logic [18:0] tbl_addr;
  logic [23:0] tbl_rdata = '0;
  logic [15:0] out_addr;
  logic [3:0]  out_req;
  logic [3:0]  out_ack = '0;

  int checks = 0, fails = 0, cyc = 0;
  int dly [4] = '{0, 0, 0, 0};
  int acnt [4] = '{0, 0, 0, 0};
  logic [18:0] rd_q[$];
  logic [15:0] pq0[$], pq1[$], pq2[$], pq3[$];
  int r5_viol = 0, r6_viol = 0, req_seen = 0;
  int age_a = 100, age_l = 100;
  logic [3:0]  req_p = '0;
  logic [15:0] addr_p = '0;

  always #2 clk = ~clk;

  fanout_sequencer dut (
    .clk(clk), .rst(rst), .job_req(job_req), .job_ptr(job_ptr), .job_cnt(job_cnt),
    .job_ack(job_ack), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
    .out_addr(out_addr), .out_req(out_req), .out_ack(out_ack)
  );

  // Table model: R3 layout; junk in [23:20]
  function automatic logic [3:0] mask_of(input logic [18:0] a);
    return a[3:0];
  endfunction
  function automatic logic [15:0] evt_of(input logic [18:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[18:16], 13'd0};
  endfunction
  function automatic logic [23:0] word_of(input logic [18:0] a);
    return {a[7:4] ^ 4'hF, mask_of(a), evt_of(a)};
  endfunction

  always @(posedge clk) if (tbl_rd) tbl_rdata <= word_of(tbl_addr);

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Monitor and port responders, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
    if (!rst) begin
      if (tbl_rd) begin
        rd_q.push_back(tbl_addr);
        if (out_req != 0 || out_ack != 0) r5_viol++;
      end
      if (out_addr != addr_p) begin
        if (age_l < 1) r6_viol++;
        age_a = 0;
      end else if (age_a < 100) age_a++;
      for (int i = 0; i < 4; i++) if (out_req[i] && !req_p[i]) begin
        req_seen++;
        if (age_a < 1) r6_viol++;
        case (i)
          0: pq0.push_back(out_addr);
          1: pq1.push_back(out_addr);
          2: pq2.push_back(out_addr);
          default: pq3.push_back(out_addr);
        endcase
      end
      if (out_req == 0 && out_ack == 0) begin
        if (age_l < 100) age_l++;
      end else age_l = 0;
      req_p = out_req;
      addr_p = out_addr;
      for (int i = 0; i < 4; i++) begin
        if (out_req[i] != out_ack[i]) begin
          if (acnt[i] >= dly[i]) begin
            out_ack[i] = out_req[i];
            acnt[i] = 0;
          end else acnt[i]++;
        end else acnt[i] = 0;
      end
    end
  end

  task automatic set_dly(input int a, input int b, input int c, input int d);
    dly[0] = a; dly[1] = b; dly[2] = c; dly[3] = d;
  endtask

  // Run one job and compare reads and per-port events with the expectation
  task automatic run_job(input logic [18:0] p, input int n, input string tag,
                         input bit scramble);
    int bad_rd, bad_p;
    logic [15:0] e0[$], e1[$], e2[$], e3[$];
    rd_q.delete(); pq0.delete(); pq1.delete(); pq2.delete(); pq3.delete();
    @(negedge clk);
    job_ptr = p; job_cnt = 13'(n); job_req = 1'b1;
    if (scramble) begin
      repeat (3) @(negedge clk);
      job_ptr = ~p; job_cnt = 13'd5;
    end
    while (!job_ack) @(negedge clk);
    job_req = 1'b0;
    @(negedge clk); @(negedge clk);
    bad_rd = (rd_q.size() != n) ? 1 : 0;
    for (int k = 0; k < n && bad_rd == 0; k++)
      if (rd_q[k] != p + 19'(n - 1 - k)) bad_rd++;
    check(bad_rd == 0, {tag, " R2 read order"}, rd_q.size(), n);
    for (int k = n - 1; k >= 0; k--) begin
      logic [18:0] a = p + 19'(k);
      if (mask_of(a)[0]) e0.push_back(evt_of(a));
      if (mask_of(a)[1]) e1.push_back(evt_of(a));
      if (mask_of(a)[2]) e2.push_back(evt_of(a));
      if (mask_of(a)[3]) e3.push_back(evt_of(a));
    end
    bad_p = (e0 != pq0) + (e1 != pq1) + (e2 != pq2) + (e3 != pq3);
    check(bad_p == 0, {tag, " R4/R3 per-port events"},
          pq0.size() + pq1.size() + pq2.size() + pq3.size(),
          e0.size() + e1.size() + e2.size() + e3.size());
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(job_ack == 0 && tbl_rd == 0 && out_req == 0, "R1 in reset",
          {job_ack, tbl_rd, out_req}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(job_ack == 0 && tbl_rd == 0 && out_req == 0, "R1 after reset",
          {job_ack, tbl_rd, out_req}, 0);
  endtask

  task automatic t_basic();
    set_dly(0, 1, 2, 3);
    run_job(19'd1000, 10, "basic", 1'b0);
  endtask

  task automatic t_all_masks();
    // entries 0x100..0x10F cover every mask, including 0101 and 0000
    set_dly(1, 0, 1, 0);
    run_job(19'h00100, 16, "all masks", 1'b0);
  endtask

  task automatic t_mask_0101();
    set_dly(0, 0, 0, 0);
    req_seen = 0;
    run_job(19'h00205, 1, "mask 0101", 1'b0);
    check(pq0.size() == 1 && pq2.size() == 1 && pq1.size() == 0 && pq3.size() == 0,
          "R4 mask 0101 ports 0,2", req_seen, 2);
  endtask

  task automatic t_zero_mask();
    req_seen = 0;
    run_job(19'h00200, 1, "zero mask", 1'b0);
    check(req_seen == 0, "R7 zero mask no request", req_seen, 0);
  endtask

  task automatic t_count_zero();
    req_seen = 0;
    run_job(19'h00300, 0, "count zero", 1'b0);
    check(rd_q.size() == 0 && req_seen == 0, "R9 count zero", rd_q.size(), 0);
  endtask

  task automatic t_same_cycle();
    set_dly(2, 2, 2, 2);
    r5_viol = 0;
    run_job(19'h0040F, 1, "same-cycle acks", 1'b0);
    run_job(19'h0041C, 4, "same-cycle acks multi", 1'b0);
    check(r5_viol == 0, "R5 read after all acks (equal)", r5_viol, 0);
  endtask

  task automatic t_stagger();
    set_dly(0, 3, 3, 7);
    r5_viol = 0;
    run_job(19'h0050A, 6, "stagger", 1'b0);
    check(r5_viol == 0, "R5 read after slowest port", r5_viol, 0);
  endtask

  task automatic t_hold_ack();
    int lows = 0, rds = 0;
    set_dly(0, 0, 0, 0);
    @(negedge clk);
    job_ptr = 19'h00611; job_cnt = 13'd2; job_req = 1'b1;
    while (!job_ack) @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      if (!job_ack) lows++;
    end
    check(lows == 0, "R8 ack held while req high", lows, 0);
    job_req = 1'b0;
    rd_q.delete();
    repeat (2) @(negedge clk);
    check(job_ack == 0, "R8 ack falls after req", job_ack, 0);
    repeat (4) @(negedge clk);
    rds = rd_q.size();
    check(rds == 0 && job_ack == 0, "R8 idle until new job", rds, 0);
    run_job(19'h00623, 3, "R8 next job", 1'b0);
  endtask

  task automatic t_latch();
    set_dly(1, 1, 1, 1);
    run_job(19'h00733, 7, "R11 inputs changed mid-job", 1'b1);
  endtask

  task automatic t_big();
    set_dly(0, 0, 0, 0);
    run_job(19'h10000, 8191, "R10 max count", 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_all_masks();
    t_mask_0101();
    t_zero_mask();
    t_count_zero();
    t_same_cycle();
    t_stagger();
    t_hold_ack();
    t_latch();
    t_big();
    check(r6_viol == 0, "R6 address guard margin", r6_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule